// File: doc/BRIEF.md
# Conditional PC-Relative Branch Unit

This block holds the program counter of a small processor whose memory is a flat space of 2^16 bytes. On each advance strobe it moves the PC past the current instruction, which is one or two bytes long. For a branch it also adds a signed 8-bit displacement. The displacement is applied to the address of the following instruction, so a taken branch lands at PC + length + offset. All PC arithmetic wraps modulo 2^16.

Five branch kinds share one displacement path. One of them always branches. The other four test a register value supplied by the datapath: negative, non-zero, zero, and strictly positive. A halt request freezes the PC and raises a sticky halted flag, which only reset clears. Fetching instructions and storing registers are done elsewhere.

Top module: `pcrel_branch_unit`

## Requirements
- R1: While `rst_n` is low, `pc` is 0 and `halted` is 0, and both stay so until the first active step after reset is released.
- R2: On an accepted step with no branch taken, `pc` advances by 2 when `len_two` is 1 and by 1 when `len_two` is 0. An accepted step is a cycle with `adv`=1, `halted`=0 and `halt_req`=0.
- R3: With class code 1 (always), every accepted step is taken, and `pc` becomes pc + length + offset.
- R4: Class code 2 (negative) is taken exactly when bit 15 of `tval` is 1.
- R5: Class code 3 (non-zero) is taken exactly when `tval` != 0. Class code 4 (zero) is taken exactly when `tval` == 0.
- R6: Class code 5 (positive) is taken exactly when bit 15 of `tval` is 0 and `tval` != 0.
- R7: `offset` is a two's-complement value, sign-extended from 8 bits. The sum wraps modulo 2^16 in both directions.
- R8: In a cycle with `adv`=0, `pc` does not change and `taken` is 0.
- R9: A cycle with `halt_req`=1 sets `halted` and leaves `pc` unchanged. Once `halted` is 1, `pc` and `halted` hold whatever the inputs do, until reset.
- R10: `taken` is combinational. It is 1 only in an accepted step whose condition holds. Class code 0 (none), and the unused codes 6 and 7, are never taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| adv | input | 1 | Advance strobe: step past the current instruction |
| halt_req | input | 1 | Halt request; has priority over `adv` |
| br_class | input | 3 | 0 none, 1 always, 2 negative, 3 non-zero, 4 zero, 5 positive |
| len_two | input | 1 | Instruction length: 1 means two bytes, 0 means one byte |
| offset | input | 8 | Signed branch displacement |
| tval | input | 16 | Value of the tested register |
| pc | output | 16 | Program counter (byte address) |
| taken | output | 1 | Branch taken in this cycle's step |
| halted | output | 1 | Sticky halt flag |

## Verification
The assertions check on every cycle that the condition for each class matches the sign and zero state of `tval`, and that `taken` never appears outside an accepted step. They also check, cycle by cycle, that a sequential step moves the PC by exactly the length, that an idle or halted cycle leaves it unchanged, and that the halt flag is sticky. Two things are left to the bench, which computes them independently: the full branch target, including sign extension and wrap at both ends of the address space, and the return to PC 0 after reset clears a halt.

// File: rtl/pcbr_pkg.sv
package pcbr_pkg;
  typedef enum logic [2:0] {
    BR_NONE   = 3'd0,
    BR_ALWAYS = 3'd1,
    BR_NEG    = 3'd2,
    BR_NZ     = 3'd3,
    BR_Z      = 3'd4,
    BR_POS    = 3'd5
  } br_class_e;

  localparam int CLASS_W = 3;
endpackage

// File: rtl/pcbr_cond.sv
module pcbr_cond
  import pcbr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [CLASS_W-1:0] cls,
  input  logic [DATA_W-1:0]  tval,
  output logic               is_neg,
  output logic               is_zero,
  output logic               hit
);
  function automatic logic eval_cond(input logic [CLASS_W-1:0] c,
                                     input logic neg, input logic zero);
    case (c)
      BR_ALWAYS: eval_cond = 1'b1;
      BR_NEG:    eval_cond = neg;
      BR_NZ:     eval_cond = !zero;
      BR_Z:      eval_cond = zero;
      BR_POS:    eval_cond = !neg && !zero;
      default:   eval_cond = 1'b0;
    endcase
  endfunction

  assign is_neg  = tval[DATA_W-1];
  assign is_zero = (tval == '0);
  assign hit     = eval_cond(cls, is_neg, is_zero);
endmodule

// File: rtl/pcbr_next.sv
module pcbr_next #(
  parameter int PC_W  = 16,
  parameter int OFF_W = 8
) (
  input  logic [PC_W-1:0]  pc_cur,
  input  logic             len_two,
  input  logic             use_off,
  input  logic [OFF_W-1:0] off,
  output logic [PC_W-1:0]  seq_pc,
  output logic [PC_W-1:0]  tgt_pc
);
  function automatic logic [PC_W-1:0] sext_off(input logic [OFF_W-1:0] o);
    sext_off = {{(PC_W-OFF_W){o[OFF_W-1]}}, o};
  endfunction

  function automatic logic [PC_W-1:0] step_len(input logic two);
    step_len = two ? PC_W'(2) : PC_W'(1);
  endfunction

  assign seq_pc = pc_cur + step_len(len_two);
  assign tgt_pc = use_off ? (seq_pc + sext_off(off)) : seq_pc;
endmodule

// File: rtl/pcrel_branch_unit.sv
module pcrel_branch_unit
  import pcbr_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int DATA_W = 16,
  parameter int OFF_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adv,
  input  logic               halt_req,
  input  logic [CLASS_W-1:0] br_class,
  input  logic               len_two,
  input  logic [OFF_W-1:0]   offset,
  input  logic [DATA_W-1:0]  tval,
  output logic [PC_W-1:0]    pc,
  output logic               taken,
  output logic               halted
);
  logic            cond_hit;
  logic            t_neg;
  logic            t_zero;
  logic            step_fire;
  logic            halt_fire;
  logic [PC_W-1:0] seq_pc;
  logic [PC_W-1:0] next_pc;

  pcbr_cond #(.DATA_W(DATA_W)) u_cond (
    .cls     (br_class),
    .tval    (tval),
    .is_neg  (t_neg),
    .is_zero (t_zero),
    .hit     (cond_hit)
  );

  assign halt_fire = halt_req && !halted;
  assign step_fire = adv && !halted && !halt_req;
  assign taken     = step_fire && cond_hit;

  pcbr_next #(.PC_W(PC_W), .OFF_W(OFF_W)) u_next (
    .pc_cur  (pc),
    .len_two (len_two),
    .use_off (taken),
    .off     (offset),
    .seq_pc  (seq_pc),
    .tgt_pc  (next_pc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc     <= '0;
      halted <= 1'b0;
    end else begin
      if (halt_fire) halted <= 1'b1;
      if (step_fire) pc <= next_pc;
    end
  end
endmodule

// File: rtl/pcrel_branch_unit_chk.sv
module pcrel_branch_unit_chk #(
  parameter int PC_W   = 16,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              adv,
  input logic              halt_req,
  input logic [2:0]        br_class,
  input logic              len_two,
  input logic [DATA_W-1:0] tval,
  input logic [PC_W-1:0]   pc,
  input logic              taken,
  input logic              halted,
  input logic              cond_hit,
  input logic              step_fire
);
  logic step_ok;
  assign step_ok = adv && !halted && !halt_req;

  AST_RESET_STATE: assert property (@(posedge clk) !rst_n |=> (pc == '0 && !halted)); // R1
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ok && !taken) |=> pc == $past(pc) + (($past(len_two)) ? PC_W'(2) : PC_W'(1))); // R2
  AST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ok && br_class == 3'd1) |-> taken); // R3
  AST_NEG_COND: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ok && br_class == 3'd2) |-> (taken == tval[DATA_W-1])); // R4
  AST_ZERO_CONDS: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ok && (br_class == 3'd3 || br_class == 3'd4)) |->
      (taken == ((br_class == 3'd4) == (tval == '0)))); // R5
  AST_POS_COND: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ok && br_class == 3'd5) |-> (taken == (!tval[DATA_W-1] && tval != '0))); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |-> (!taken ##1 $stable(pc))); // R8
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (halted || halt_req) |=> (halted && $stable(pc))); // R9
  AST_TAKEN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    taken |-> (step_fire && cond_hit && br_class != 3'd0 && br_class < 3'd6)); // R10
endmodule

bind pcrel_branch_unit pcrel_branch_unit_chk #(.PC_W(PC_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .adv       (adv),
  .halt_req  (halt_req),
  .br_class  (br_class),
  .len_two   (len_two),
  .tval      (tval),
  .pc        (pc),
  .taken     (taken),
  .halted    (halted),
  .cond_hit  (cond_hit),
  .step_fire (step_fire)
);

// File: tb/test_pcrel_branch_unit.sv
`timescale 1ns/1ps
module test_pcrel_branch_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        adv = 1'b0;
  logic        halt_req = 1'b0;
  logic [2:0]  br_class = '0;
  logic        len_two = 1'b0;
  logic [7:0]  offset = '0;
  logic [15:0] tval = '0;
  logic [15:0] pc;
  logic        taken;
  logic        halted;

  int n_vec = 0;
  int n_bad = 0;
  logic [15:0] m_pc = '0;
  logic        m_halt = 1'b0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  pcrel_branch_unit i_pcrel_branch_unit (
    .clk(clk), .rst_n(rst_n), .adv(adv), .halt_req(halt_req),
    .br_class(br_class), .len_two(len_two), .offset(offset), .tval(tval),
    .pc(pc), .taken(taken), .halted(halted)
  );

  function automatic bit want_branch(input logic [2:0] c, input logic [15:0] v);
    int s;
    s = $signed(v);
    case (c)
      3'd1: return 1;
      3'd2: return s < 0;
      3'd3: return v != 0;
      3'd4: return v == 0;
      3'd5: return s > 0;
      default: return 0;
    endcase
  endfunction

  function automatic logic [15:0] want_pc(input logic [15:0] p, input logic two,
                                          input bit br, input logic [7:0] o);
    int sum;
    sum = int'(p) + (two ? 2 : 1) + (br ? int'($signed(o)) : 0);
    return 16'(sum & 32'hFFFF);
  endfunction

  function automatic string tag_of(input logic [2:0] c);
    case (c)
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3, 3'd4: return "R5";
      3'd5: return "R6";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic a, input logic h, input logic [2:0] c,
                      input logic two, input logic [7:0] o, input logic [15:0] v,
                      input string req);
    bit acc, br;
    @(negedge clk);
    adv = a; halt_req = h; br_class = c; len_two = two; offset = o; tval = v;
    #0.5;
    acc = a && !m_halt && !h;
    br  = acc && want_branch(c, v);
    check({req, "/taken"}, 32'(taken), 32'(br));
    @(posedge clk);
    #0.5;
    if (acc) m_pc = want_pc(m_pc, two, br, o);
    if (h) m_halt = 1'b1;
    check({req, "/pc"}, 32'(pc), 32'(m_pc));
    check({req, "/halted"}, 32'(halted), 32'(m_halt));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; adv = 0; halt_req = 0;
    #1;
    check("R1/pc", 32'(pc), 0);
    check("R1/halted", 32'(halted), 0);
    @(negedge clk);
    rst_n = 1'b1;
    m_pc = '0; m_halt = 1'b0;
  endtask

  initial begin
    #(4.0 * 200000);
    if (!done) begin
      n_bad++; n_vec++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5EED;
    void'($urandom(seed));
    repeat (2) @(posedge clk);
    do_reset();
    // directed corners
    step(1, 0, 3'd0, 1'b0, 8'h55, 16'h0000, "R2");
    step(1, 0, 3'd0, 1'b1, 8'h55, 16'h0000, "R2");
    step(1, 0, 3'd1, 1'b1, 8'hFE, 16'h1234, "R3");
    step(1, 0, 3'd1, 1'b0, 8'h80, 16'h0000, "R7");   // backward wrap below 0
    step(1, 0, 3'd2, 1'b1, 8'h04, 16'h8000, "R4");
    step(1, 0, 3'd2, 1'b1, 8'h04, 16'h7FFF, "R4");
    step(1, 0, 3'd3, 1'b0, 8'h10, 16'h0000, "R5");
    step(1, 0, 3'd4, 1'b0, 8'h10, 16'h0000, "R5");
    step(1, 0, 3'd5, 1'b1, 8'h08, 16'h0000, "R6");
    step(1, 0, 3'd5, 1'b1, 8'h08, 16'h8001, "R6");
    step(1, 0, 3'd5, 1'b1, 8'h08, 16'h0001, "R6");
    step(1, 0, 3'd6, 1'b1, 8'h20, 16'h0001, "R10");
    step(1, 0, 3'd7, 1'b1, 8'h20, 16'h8000, "R10");
    step(0, 0, 3'd1, 1'b1, 8'h20, 16'h0000, "R8");
    step(1, 0, 3'd1, 1'b1, 8'h7F, 16'h0000, "R7");
    step(1, 1, 3'd1, 1'b1, 8'h10, 16'h0000, "R9");   // halt wins over advance
    step(1, 0, 3'd1, 1'b1, 8'h10, 16'h0000, "R9");
    step(1, 0, 3'd4, 1'b0, 8'h10, 16'h0000, "R9");
    do_reset();
    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [2:0]  c;
      logic [15:0] v;
      logic        a, h;
      c = 3'($urandom_range(0, 7));
      case ($urandom_range(0, 3))
        0: v = 16'h0000;
        1: v = 16'h8000 | 16'($urandom);
        default: v = 16'($urandom);
      endcase
      a = ($urandom_range(0, 9) != 0);
      h = ($urandom_range(0, 499) == 0);
      step(a, h, c, 1'($urandom), 8'($urandom), v, tag_of(c));
      if (m_halt && $urandom_range(0, 7) == 0) do_reset();
    end
    // forward wrap past the top of the address space
    do_reset();
    step(1, 0, 3'd1, 1'b1, 8'hFD, 16'h0000, "R7");
    step(1, 0, 3'd1, 1'b0, 8'h03, 16'h0000, "R7");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule